// File: doc/BRIEF.md
# LIN Transceiver Mode Controller

This block is the digital control core of a single-wire LIN bus transceiver. It takes an enable request from the host controller, a supply-undervoltage flag, an over-temperature flag, the transmit data line and the output of the bus receive comparator. From these it decides the operating mode (battery standby, normal and sleep, with a thermal overlay) and drives three signals: the enable for the external voltage regulator, the gate that allows the bus driver to pull the line dominant, and the receive data line back to the host.

The enable input and the received bus level both pass through duration filters, so brief glitches do not change the mode or reach the host. While asleep, the block watches the raw bus for a dominant level that lasts long enough to count as a remote wakeup request. When one arrives it switches the regulator back on and pulls the receive line low as an interrupt until the host moves the transceiver to normal mode. Every time constant is a clock-cycle count set by a parameter. All inputs are assumed synchronous to `clk`.

Top module: `lin_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, at a rising clock edge the block enters battery standby (`mode_o` = 2'b00), with `inh_o` = 1, `rxd_o` = 1, `tx_dom_o` = 0 and `therm_act_o` = 0.
- R2: Mode codes are 2'b00 standby, 2'b01 normal and 2'b10 sleep. From standby the block enters normal one edge after the filtered enable becomes high, provided `vcc_uv_i` is low at that edge.
- R3: The filtered enable changes only after `en_i` has held the new level for EN_DEB_CYC consecutive clock samples. Shorter pulses have no effect on the mode.
- R4: Sleep is entered only from normal, one edge after the filtered enable goes low. `inh_o` is 0 in sleep and 1 in every other mode.
- R5: `vcc_uv_i` high in normal moves the block to standby at the next edge. While it stays high, normal cannot be entered, and the transmit gate stays off.
- R6: In sleep, `rx_cmp_i` = 0 (dominant) sampled on WAKE_CYC consecutive edges moves the block to standby at the last of those edges. Shorter dominant pulses leave it asleep.
- R7: After a remote wakeup, `rxd_o` is held at 0 until normal mode is entered, whatever the bus level.
- R8: `tx_dom_o` is 1 in the cycle after an edge at which the next mode is normal and `txd_i`, `therm_i` and `vcc_uv_i` were all 0. Otherwise it is 0.
- R9: `therm_act_o` follows `therm_i` with one cycle of latency. The thermal flag changes neither the mode nor the receive path.
- R10: Outside sleep and the wakeup interrupt, `rxd_o` follows `rx_cmp_i` after it has held a level for RX_DEB_CYC consecutive samples. Shorter spikes are dropped. In sleep, `rxd_o` is 1.
- R11: The filtered enable going high in sleep (with `vcc_uv_i` low) moves the block directly to normal, and no wakeup interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on) |
| en_i | input | 1 | Mode request from host, high requests normal |
| vcc_uv_i | input | 1 | Logic supply undervoltage flag |
| therm_i | input | 1 | Over-temperature flag |
| txd_i | input | 1 | Transmit data, 0 = dominant |
| rx_cmp_i | input | 1 | Bus comparator output, 0 = dominant |
| inh_o | output | 1 | Regulator enable, 1 = driven high, 0 = released |
| tx_dom_o | output | 1 | Bus driver gate, 1 = pull bus dominant |
| rxd_o | output | 1 | Receive data / wakeup interrupt, 0 = dominant or interrupt |
| mode_o | output | 2 | Current mode code |
| therm_act_o | output | 1 | Registered thermal overlay flag |

## Verification
On every cycle, the assertions check the following: sleep is never reached straight from standby, undervoltage always ejects normal mode, a thermal flag always silences the driver, the driver only pulls when the block is in normal mode, the interrupt flag only exists in standby with the receive line low, a recessive bus never wakes the block, and the filters change level only after the input holds that level. The timing of each transition, the exact pulse length at which the filters accept or reject, and the interrupt being held across bus activity until normal mode is entered can only be shown by the bench scenarios, which are checked against a behavioural reference model on every clock.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;
    typedef enum logic [1:0] {
        MODE_STBY  = 2'b00,
        MODE_NORM  = 2'b01,
        MODE_SLEEP = 2'b10
    } lin_mode_e;
endpackage

// File: rtl/lin_deglitch.sv
// Level filter: output takes a new level only after the input has shown
// it for HOLD_CYC consecutive samples; any return restarts the count.
module lin_deglitch #(
    parameter int   HOLD_CYC = 4,
    parameter logic RST_VAL  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din_i,
    output logic dout_o
);
    localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          val;
    } flt_t;

    flt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (din_i == st_q.val) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == LAST) begin
            st_d.val = din_i;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.val <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout_o = st_q.val;

    // R3 (enable instance) and R10 (receive instance)
    a_r10_flip_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.val) |-> ($past(din_i) == st_q.val));
endmodule

// File: rtl/lin_wake_qual.sv
// Remote wakeup qualifier: fires when the bus has been dominant for
// HOLD_CYC consecutive samples while armed.
module lin_wake_qual #(
    parameter int HOLD_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic dom_i,
    output logic wake_o
);
    localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          hit;

    always_comb begin
        hit   = arm_i && dom_i && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!arm_i || !dom_i || hit) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign wake_o = hit;

    generate
        if (HOLD_CYC > 1) begin : g_chk
            a_r6_wake_needs_prior_dom: assert property (@(posedge clk) disable iff (!rst_n)
                wake_o |-> ($past(dom_i) && $past(arm_i)));
        end
    endgenerate
endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl
    import lin_mode_pkg::*;
#(
    parameter int EN_DEB_CYC = 2000,
    parameter int RX_DEB_CYC = 300,
    parameter int WAKE_CYC   = 6000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       vcc_uv_i,
    input  logic       therm_i,
    input  logic       txd_i,
    input  logic       rx_cmp_i,
    output logic       inh_o,
    output logic       tx_dom_o,
    output logic       rxd_o,
    output logic [1:0] mode_o,
    output logic       therm_act_o
);
    typedef struct packed {
        lin_mode_e mode;
        logic      wake;
        logic      tx_dom;
        logic      therm;
    } ctl_t;

    ctl_t st_d, st_q;
    logic en_f;
    logic rx_f;
    logic wake_hit;

    lin_deglitch #(.HOLD_CYC(EN_DEB_CYC), .RST_VAL(1'b0)) u_en_flt (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_i  (en_i),
        .dout_o (en_f)
    );

    lin_deglitch #(.HOLD_CYC(RX_DEB_CYC), .RST_VAL(1'b1)) u_rx_flt (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_i  (rx_cmp_i),
        .dout_o (rx_f)
    );

    lin_wake_qual #(.HOLD_CYC(WAKE_CYC)) u_wake (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm_i  (st_q.mode == MODE_SLEEP),
        .dom_i  (!rx_cmp_i),
        .wake_o (wake_hit)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.mode)
            MODE_STBY: begin
                if (en_f && !vcc_uv_i) st_d.mode = MODE_NORM;
            end
            MODE_NORM: begin
                if (vcc_uv_i)   st_d.mode = MODE_STBY;
                else if (!en_f) st_d.mode = MODE_SLEEP;
            end
            MODE_SLEEP: begin
                if (en_f && !vcc_uv_i) begin
                    st_d.mode = MODE_NORM;
                end else if (wake_hit) begin
                    st_d.mode = MODE_STBY;
                    st_d.wake = 1'b1;
                end
            end
            default: st_d.mode = MODE_STBY;
        endcase
        if (st_d.mode == MODE_NORM) st_d.wake = 1'b0;
        st_d.tx_dom = (st_d.mode == MODE_NORM) && !txd_i && !therm_i && !vcc_uv_i;
        st_d.therm  = therm_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode   <= MODE_STBY;
            st_q.wake   <= 1'b0;
            st_q.tx_dom <= 1'b0;
            st_q.therm  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (st_q.wake)                     rxd_o = 1'b0;
        else if (st_q.mode == MODE_SLEEP)  rxd_o = 1'b1;
        else                               rxd_o = rx_f;
    end

    assign inh_o       = (st_q.mode != MODE_SLEEP);
    assign tx_dom_o    = st_q.tx_dom;
    assign mode_o      = st_q.mode;
    assign therm_act_o = st_q.therm;

    a_r4_no_sleep_from_stby: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_STBY) |=> (st_q.mode != MODE_SLEEP));

    a_r5_uv_leaves_normal: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_NORM && vcc_uv_i) |=> (st_q.mode == MODE_STBY));

    a_r9_therm_blocks_tx: assert property (@(posedge clk) disable iff (!rst_n)
        therm_i |=> !tx_dom_o);

    a_r8_tx_only_normal: assert property (@(posedge clk) disable iff (!rst_n)
        tx_dom_o |-> (mode_o == 2'b01));

    a_r7_irq_in_standby: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wake |-> (st_q.mode == MODE_STBY && rxd_o == 1'b0));

    a_r6_recessive_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_SLEEP && rx_cmp_i && !en_f) |=> (st_q.mode != MODE_STBY));
endmodule

// File: tb/lin_mode_ctrl_tb.sv
module lin_mode_ctrl_tb;
    localparam int EN_N = 4;
    localparam int RX_N = 3;
    localparam int WK_N = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, uv = 1'b0, th = 1'b0, txd = 1'b1, rxc = 1'b1;
    logic inh, txdom, rxd, tact;
    logic [1:0] mode;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    lin_mode_ctrl #(.EN_DEB_CYC(EN_N), .RX_DEB_CYC(RX_N), .WAKE_CYC(WK_N)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en),
        .vcc_uv_i    (uv),
        .therm_i     (th),
        .txd_i       (txd),
        .rx_cmp_i    (rxc),
        .inh_o       (inh),
        .tx_dom_o    (txdom),
        .rxd_o       (rxd),
        .mode_o      (mode),
        .therm_act_o (tact)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_mode, m_wake, m_tx, m_th, m_en_f, m_en_c, m_rx_f, m_rx_c, m_wk_c, nm, fire;
    bit m_on = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_wake = 0; m_tx = 0; m_th = 0;
            m_en_f = 0; m_en_c = 0; m_rx_f = 1; m_rx_c = 0; m_wk_c = 0;
            m_on = 1;
        end else begin
            fire = (m_mode == 2 && rxc == 0 && m_wk_c == WK_N - 1) ? 1 : 0;
            nm = m_mode;
            if (m_mode == 0) begin
                if (m_en_f == 1 && !uv) nm = 1;
            end else if (m_mode == 1) begin
                if (uv) nm = 0;
                else if (m_en_f == 0) nm = 2;
            end else begin
                if (m_en_f == 1 && !uv) nm = 1;
                else if (fire == 1) begin nm = 0; m_wake = 1; end
            end
            if (nm == 1) m_wake = 0;
            if (m_mode != 2 || rxc == 1 || fire == 1) m_wk_c = 0; else m_wk_c++;
            if (int'(en) == m_en_f) m_en_c = 0;
            else if (m_en_c == EN_N - 1) begin m_en_f = int'(en); m_en_c = 0; end
            else m_en_c++;
            if (int'(rxc) == m_rx_f) m_rx_c = 0;
            else if (m_rx_c == RX_N - 1) begin m_rx_f = int'(rxc); m_rx_c = 0; end
            else m_rx_c++;
            m_tx   = (nm == 1 && !txd && !th && !uv) ? 1 : 0;
            m_th   = int'(th);
            m_mode = nm;
        end
    end

    always @(negedge clk) begin
        if (m_on && rst_n) begin
            chk("R2 model mode", int'(mode), m_mode);
            chk("R4 model inh", int'(inh), (m_mode != 2) ? 1 : 0);
            chk("R8 model tx_dom", int'(txdom), m_tx);
            chk("R9 model therm_act", int'(tact), m_th);
            chk("R10 model rxd", int'(rxd), m_wake ? 0 : ((m_mode == 2) ? 1 : m_rx_f));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=1 expected=0");
        finish_run();
    end

    initial begin
        tick(3);
        // R1 reset state
        chk("R1 mode", int'(mode), 0);
        chk("R1 inh", int'(inh), 1);
        chk("R1 rxd", int'(rxd), 1);
        chk("R1 tx_dom", int'(txdom), 0);
        chk("R1 therm_act", int'(tact), 0);
        rst_n = 1'b1;
        tick(10);
        chk("R4 standby keeps inh", int'(inh), 1);
        chk("R4 no sleep from standby", int'(mode), 0);

        // R3 short enable pulse
        en = 1'b1; tick(EN_N - 1); en = 1'b0; tick(8);
        chk("R3 short en ignored", int'(mode), 0);

        // R2 enter normal
        en = 1'b1; tick(EN_N);
        chk("R2 not yet normal", int'(mode), 0);
        tick(1);
        chk("R2 normal", int'(mode), 1);

        // R8 transmit path
        txd = 1'b0; tick(1);
        chk("R8 dominant", int'(txdom), 1);
        txd = 1'b1; tick(1);
        chk("R8 recessive", int'(txdom), 0);

        // R9 thermal overlay with receive path active
        th = 1'b1; txd = 1'b0; rxc = 1'b0; tick(1);
        chk("R9 therm_act", int'(tact), 1);
        chk("R9 tx gated", int'(txdom), 0);
        tick(RX_N - 2);
        chk("R10 rx before hold", int'(rxd), 1);
        tick(1);
        chk("R10 rx after hold", int'(rxd), 0);
        chk("R9 mode kept", int'(mode), 1);
        th = 1'b0; rxc = 1'b1; tick(1);
        chk("R9 tx resumes", int'(txdom), 1);
        txd = 1'b1; tick(RX_N + 1);
        chk("R10 rx back", int'(rxd), 1);

        // R10 spike filtered
        rxc = 1'b0; tick(RX_N - 1); rxc = 1'b1; tick(4);
        chk("R10 spike dropped", int'(rxd), 1);

        // R5 undervoltage
        uv = 1'b1; txd = 1'b0; tick(1);
        chk("R5 uv to standby", int'(mode), 0);
        chk("R5 tx off", int'(txdom), 0);
        tick(5);
        chk("R5 uv blocks normal", int'(mode), 0);
        uv = 1'b0; txd = 1'b1; tick(1);
        chk("R5 recover normal", int'(mode), 1);

        // R4 sleep
        en = 1'b0; tick(EN_N + 1);
        chk("R4 sleep", int'(mode), 2);
        chk("R4 inh released", int'(inh), 0);
        chk("R10 rxd high in sleep", int'(rxd), 1);

        // R6 short dominant ignored
        rxc = 1'b0; tick(WK_N - 1); rxc = 1'b1; tick(3);
        chk("R6 short wake ignored", int'(mode), 2);

        // R6/R7 remote wakeup
        rxc = 1'b0; tick(WK_N - 1);
        chk("R6 still asleep", int'(mode), 2);
        tick(1);
        chk("R6 woke to standby", int'(mode), 0);
        chk("R6 inh on", int'(inh), 1);
        chk("R7 irq low", int'(rxd), 0);
        rxc = 1'b1; tick(6);
        chk("R7 irq held", int'(rxd), 0);
        en = 1'b1; tick(EN_N + 1);
        chk("R7 normal entered", int'(mode), 1);
        chk("R7 irq cleared", int'(rxd), 1);

        // R11 local wakeup
        en = 1'b0; tick(EN_N + 1);
        chk("R11 asleep", int'(mode), 2);
        en = 1'b1; tick(EN_N + 1);
        chk("R11 direct normal", int'(mode), 1);
        chk("R11 no irq", int'(rxd), 1);

        tick(4);
        finish_run();
    end
endmodule